// File: doc/BRIEF.md
# Double-Buffered Colour Palette

This block turns an 8-bit pixel index into a 24-bit colour for the display path. It keeps two complete palette banks. The display always reads the bank that is marked active. The CPU writes into the other bank through a small word-addressed register port, so a palette can be rebuilt while the current one stays on screen.

To hand a finished palette to the display, software inverts a swap-request bit in the control word. The swap is carried out at the next vertical-blanking start pulse. At that same edge a read-only status bit takes the value of the request bit. While the two bits differ, the swap is still pending. Once they match, the swap is done, the bank that was active has become the writable one, and software must refill all entries before it requests the next swap.

Top module: `pal_dbuf`

## Requirements
- R1: After reset the control word reads 0, meaning request bit 0 = 0 and status bit 1 = 0. Bank 0 is active, `pix_rgb_valid` is 0 and `pix_rgb` is 0.
- R2: A write with `cpu_we` to address PAL_BASE + 4*n (default PAL_BASE 0x400) stores `cpu_wdata[23:0]` as entry n of the bank not in use. Red is in bits 23:16, green in 15:8 and blue in 7:0. The active bank, and so every lookup, is unchanged.
- R3: A write to the control address (default 0x020) loads the request bit from `cpu_wdata[0]`. `cpu_wdata[1]` has no effect on the status bit. A control read returns the request bit in bit 0, the status bit in bit 1, and zeros above.
- R4: When `vblank_start` is high and the request bit differs from the status bit, the status bit takes the request value at that clock edge and the display switches to that bank. Without `vblank_start` the status bit holds, so a request stays pending.
- R5: `vblank_start` while the request bit equals the status bit changes neither the status bit nor the active bank.
- R6: `pix_valid` with `pix_index` produces, one clock later, `pix_rgb_valid` = 1 and `pix_rgb` = the entry of the active bank. In a cycle without `pix_valid`, `pix_rgb_valid` is 0 on the next clock and `pix_rgb` holds its value.
- R7: `cpu_re` returns, on the next clock in `cpu_rdata`, one of the following: the addressed entry of the bank not in use, zero-extended to 32 bits; the control word; or 0 for any address that is neither of those.
- R8: Suppose a swap, a lookup and a palette write all fall on the same clock edge. The lookup returns the entry from the bank that was active before the swap. The write lands in the bank that was not in use before the swap, which is the bank that becomes active.
- R9: A palette-region write whose address has bits 1:0 not equal to 00 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | ADDR_W (12) | Byte address of the register access |
| cpu_we | input | 1 | Write strobe |
| cpu_re | input | 1 | Read strobe; data appears one clock later |
| cpu_wdata | input | DATA_W (32) | Write data |
| cpu_rdata | output | DATA_W (32) | Registered read data |
| vblank_start | input | 1 | One-cycle pulse at the start of vertical blanking |
| pix_valid | input | 1 | Lookup request strobe |
| pix_index | input | IDX_W (8) | Pixel palette index |
| pix_rgb_valid | output | 1 | Lookup result valid |
| pix_rgb | output | 24 | Looked-up colour, packed R:G:B |

## Verification
The risky case is a frame-sync swap that lands in the same cycle as a display lookup and a CPU palette write. The bench sets up a pending request and then raises `vblank_start`, `pix_valid` and `cpu_we` on the same clock. It expects the lookup to return the old bank's colour, the status bit to flip, and a later lookup of the written index to return the newly written colour from the now-active bank. Before that, it checks that a pending request does not move the display before blanking, and that CPU readback shows only the bank not in use.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int unsigned COLOR_W = 24;
  localparam int unsigned NBANKS  = 2;

  typedef logic [COLOR_W-1:0] rgb_t;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_CTRL  = 2'd1,
    ACC_ENTRY = 2'd2
  } acc_e;
endpackage

// File: rtl/pal_swap_ctrl.sv
module pal_swap_ctrl (
  input  logic clk,
  input  logic rst_ni,
  input  logic ctrl_we_i,
  input  logic ctrl_wbit_i,
  input  logic vblank_i,
  output logic switch_o,
  output logic status_o
);
  logic switch_q, switch_d;
  logic status_q, status_d;
  logic swap_now;

  // the swap happens only at blanking and only while a request is pending
  assign swap_now = vblank_i && (switch_q != status_q);

  always_comb begin
    switch_d = switch_q;
    status_d = status_q;
    if (ctrl_we_i) switch_d = ctrl_wbit_i;
    if (swap_now)  status_d = switch_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      switch_q <= 1'b0;
      status_q <= 1'b0;
    end else begin
      switch_q <= switch_d;
      status_q <= status_d;
    end
  end

  assign switch_o = switch_q;
  assign status_o = status_q;

  a_r4_swap_on_vblank: assert property (@(posedge clk) disable iff (!rst_ni)
    (vblank_i && (switch_o != status_o)) |=> (status_o == $past(switch_o)));
  a_r4_status_holds_without_vblank: assert property (@(posedge clk) disable iff (!rst_ni)
    !vblank_i |=> $stable(status_o));
  a_r5_no_move_when_equal: assert property (@(posedge clk) disable iff (!rst_ni)
    (vblank_i && (switch_o == status_o)) |=> $stable(status_o));
  a_r3_request_follows_write: assert property (@(posedge clk) disable iff (!rst_ni)
    ctrl_we_i |=> (switch_o == $past(ctrl_wbit_i)));
endmodule

// File: rtl/pal_bank_store.sv
module pal_bank_store
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             wr_en_i,
  input  logic             wr_bank_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  rgb_t             wr_data_i,
  input  logic             lk_bank_i,
  input  logic [IDX_W-1:0] lk_idx_i,
  output rgb_t             lk_data_o,
  input  logic             cpu_bank_i,
  input  logic [IDX_W-1:0] cpu_idx_i,
  output rgb_t             cpu_data_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  rgb_t lk_rd  [NBANKS];
  rgb_t cpu_rd [NBANKS];

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    rgb_t mem [DEPTH];
    logic bank_we;

    assign bank_we = wr_en_i && (wr_bank_i == 1'(b));

    always_ff @(posedge clk) begin
      if (bank_we) mem[wr_idx_i] <= wr_data_i;
    end

    assign lk_rd[b]  = mem[lk_idx_i];
    assign cpu_rd[b] = mem[cpu_idx_i];
  end

  assign lk_data_o  = lk_rd[lk_bank_i];
  assign cpu_data_o = cpu_rd[cpu_bank_i];
endmodule

// File: rtl/pal_lookup.sv
module pal_lookup
  import pal_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic valid_i,
  input  rgb_t data_i,
  output logic valid_o,
  output rgb_t rgb_o
);
  logic valid_q, valid_d;
  rgb_t rgb_q, rgb_d;

  always_comb begin
    valid_d = valid_i;
    rgb_d   = rgb_q;
    if (valid_i) rgb_d = data_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      rgb_q   <= '0;
    end else begin
      valid_q <= valid_d;
      rgb_q   <= rgb_d;
    end
  end

  assign valid_o = valid_q;
  assign rgb_o   = rgb_q;

  a_r6_valid_follows_strobe: assert property (@(posedge clk) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r6_idle_holds_colour: assert property (@(posedge clk) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(rgb_o)));
endmodule

// File: rtl/pal_dbuf.sv
module pal_dbuf
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CTRL_ADDR = 'h020,
  parameter int unsigned PAL_BASE  = 'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic              cpu_re,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              vblank_start,
  input  logic              pix_valid,
  input  logic [IDX_W-1:0]  pix_index,
  output logic              pix_rgb_valid,
  output logic [23:0]       pix_rgb
);
  localparam int unsigned REGION_LSB = IDX_W + 2;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(PAL_BASE);

  // reset: asserted at once, released after two clocks
  logic rst_meta_q, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s      <= rst_meta_q;
    end
  end

  // address decode
  acc_e             acc;
  logic [IDX_W-1:0] cpu_idx;
  always_comb begin
    acc = ACC_NONE;
    if (cpu_addr == CTRL_A)
      acc = ACC_CTRL;
    else if ((cpu_addr[ADDR_W-1:REGION_LSB] == BASE_A[ADDR_W-1:REGION_LSB]) &&
             (cpu_addr[1:0] == 2'b00))
      acc = ACC_ENTRY;
  end
  assign cpu_idx = cpu_addr[REGION_LSB-1:2];

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^cpu_wdata[DATA_W-1:COLOR_W];

  logic switch_bit, status_bit;
  pal_swap_ctrl i_swap (
    .clk         (clk),
    .rst_ni      (rst_s),
    .ctrl_we_i   (cpu_we && (acc == ACC_CTRL)),
    .ctrl_wbit_i (cpu_wdata[0]),
    .vblank_i    (vblank_start),
    .switch_o    (switch_bit),
    .status_o    (status_bit)
  );

  rgb_t lk_data, cpu_entry;
  pal_bank_store #(.IDX_W(IDX_W)) i_store (
    .clk        (clk),
    .wr_en_i    (cpu_we && (acc == ACC_ENTRY)),
    .wr_bank_i  (~status_bit),
    .wr_idx_i   (cpu_idx),
    .wr_data_i  (cpu_wdata[COLOR_W-1:0]),
    .lk_bank_i  (status_bit),
    .lk_idx_i   (pix_index),
    .lk_data_o  (lk_data),
    .cpu_bank_i (~status_bit),
    .cpu_idx_i  (cpu_idx),
    .cpu_data_o (cpu_entry)
  );

  rgb_t lk_rgb;
  pal_lookup i_lookup (
    .clk     (clk),
    .rst_ni  (rst_s),
    .valid_i (pix_valid),
    .data_i  (lk_data),
    .valid_o (pix_rgb_valid),
    .rgb_o   (lk_rgb)
  );
  assign pix_rgb = lk_rgb;

  // registered read data
  logic [DATA_W-1:0] rdata_q, rdata_d;
  always_comb begin
    rdata_d = rdata_q;
    if (cpu_re) begin
      unique case (acc)
        ACC_CTRL:  rdata_d = DATA_W'({status_bit, switch_bit});
        ACC_ENTRY: rdata_d = DATA_W'(cpu_entry);
        default:   rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end
  assign cpu_rdata = rdata_q;

  a_r7_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_s)
    (cpu_re && (acc == ACC_NONE)) |=> (cpu_rdata == '0));
  a_r3_status_not_cpu_written: assert property (@(posedge clk) disable iff (!rst_s)
    (cpu_we && (acc == ACC_CTRL) && !vblank_start) |=> $stable(status_bit));
endmodule

// File: tb/test_pal_dbuf.sv
module test_pal_dbuf;
  localparam int unsigned BASE = 'h400;
  localparam int unsigned CTRL = 'h020;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] cpu_addr;
  logic        cpu_we, cpu_re;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic        vblank_start, pix_valid;
  logic [7:0]  pix_index;
  logic        pix_rgb_valid;
  logic [23:0] pix_rgb;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  pal_dbuf i_pal_dbuf (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_re(cpu_re), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .vblank_start(vblank_start), .pix_valid(pix_valid), .pix_index(pix_index),
    .pix_rgb_valid(pix_rgb_valid), .pix_rgb(pix_rgb)
  );

  function automatic logic [23:0] pat_a(input int n);
    logic [7:0] v = 8'(n);
    return {v, ~v, v ^ 8'h5a};
  endfunction
  function automatic logic [23:0] pat_b(input int n);
    logic [7:0] v = 8'(n);
    return {v ^ 8'h33, v + 8'd1, ~v};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    cpu_we = 0; cpu_re = 0; vblank_start = 0; pix_valid = 0;
  endtask

  task automatic cpu_write(input int addr, input logic [31:0] data);
    @(negedge clk);
    cpu_addr = 12'(addr); cpu_wdata = data; cpu_we = 1;
    @(negedge clk);
    cpu_we = 0;
  endtask

  task automatic cpu_read(input int addr, output logic [31:0] data);
    @(negedge clk);
    cpu_addr = 12'(addr); cpu_re = 1;
    @(negedge clk);
    cpu_re = 0;
    data = cpu_rdata;
  endtask

  task automatic lookup(input int idx, output logic [23:0] rgb, output logic vld);
    @(negedge clk);
    pix_index = 8'(idx); pix_valid = 1;
    @(negedge clk);
    pix_valid = 0;
    rgb = pix_rgb; vld = pix_rgb_valid;
  endtask

  task automatic vblank();
    @(negedge clk);
    vblank_start = 1;
    @(negedge clk);
    vblank_start = 0;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    rst_n = 0; idle(); cpu_addr = '0; cpu_wdata = '0; pix_index = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 lookup valid", 32'(pix_rgb_valid), 32'd0);
    check("R1 lookup colour", 32'(pix_rgb), 32'd0);
    check("R1 read data", cpu_rdata, 32'd0);
    cpu_read(CTRL, r);
    check("R1 control word", r, 32'd0);
  endtask

  task automatic t_first_swap();
    logic [31:0] r; logic [23:0] c; logic v;
    for (int n = 0; n < 256; n++) cpu_write(BASE + 4*n, {8'hc3, pat_a(n)});
    cpu_read(BASE + 4*17, r);
    check("R7 readback of filled bank", r, 32'(pat_a(17)));
    cpu_write(CTRL, 32'd1);
    cpu_read(CTRL, r);
    check("R4 pending request visible", r, 32'd1);
    vblank();
    cpu_read(CTRL, r);
    check("R4 swap completed", r, 32'd3);
    for (int n = 0; n < 256; n += 15) begin
      lookup(n, c, v);
      check("R6 lookup valid", 32'(v), 32'd1);
      check("R6 lookup bank A", 32'(c), 32'(pat_a(n)));
    end
    lookup(255, c, v);
    check("R6 lookup top index", 32'(c), 32'(pat_a(255)));
  endtask

  task automatic t_refill_and_pending();
    logic [31:0] r; logic [23:0] c; logic v;
    for (int n = 0; n < 256; n++) cpu_write(BASE + 4*n, 32'(pat_b(n)));
    lookup(40, c, v);
    check("R2 write does not disturb display", 32'(c), 32'(pat_a(40)));
    cpu_read(BASE + 4*40, r);
    check("R7 read shows inactive bank", r, 32'(pat_b(40)));
    cpu_write(CTRL, 32'd0);
    repeat (3) @(negedge clk);
    cpu_read(CTRL, r);
    check("R4 still pending before blanking", r, 32'd2);
    lookup(40, c, v);
    check("R4 display unchanged while pending", 32'(c), 32'(pat_a(40)));
    vblank();
    lookup(40, c, v);
    check("R4 display switched at blanking", 32'(c), 32'(pat_b(40)));
    cpu_read(CTRL, r);
    check("R4 status follows request", r, 32'd0);
  endtask

  task automatic t_no_pending_vblank();
    logic [31:0] r; logic [23:0] c; logic v;
    vblank();
    cpu_read(CTRL, r);
    check("R5 control unchanged", r, 32'd0);
    lookup(99, c, v);
    check("R5 display unchanged", 32'(c), 32'(pat_b(99)));
  endtask

  task automatic t_idle_lookup();
    logic [23:0] c; logic v;
    lookup(3, c, v);
    @(negedge clk);
    check("R6 idle valid low", 32'(pix_rgb_valid), 32'd0);
    check("R6 idle colour held", 32'(pix_rgb), 32'(pat_b(3)));
  endtask

  task automatic t_same_cycle();
    logic [31:0] r; logic [23:0] c; logic v;
    cpu_write(CTRL, 32'd3);
    cpu_read(CTRL, r);
    check("R3 bit1 write ignored", r, 32'd1);
    @(negedge clk);
    vblank_start = 1; pix_valid = 1; pix_index = 8'd5;
    cpu_addr = 12'(BASE + 4*7); cpu_wdata = 32'h00abcdef; cpu_we = 1;
    @(negedge clk);
    idle();
    check("R8 lookup uses pre-swap bank", 32'(pix_rgb), 32'(pat_b(5)));
    cpu_read(CTRL, r);
    check("R8 swap taken", r, 32'd3);
    lookup(7, c, v);
    check("R8 write landed in new active bank", 32'(c), 32'h00abcdef);
    lookup(5, c, v);
    check("R8 new active bank is A", 32'(c), 32'(pat_a(5)));
  endtask

  task automatic t_misaligned_unmapped();
    logic [31:0] r;
    cpu_write(BASE + 4*9 + 1, 32'h00123456);
    cpu_read(BASE + 4*9, r);
    check("R9 misaligned write ignored", r, 32'(pat_b(9)));
    cpu_read(CTRL + 4, r);
    check("R7 unmapped read zero", r, 32'd0);
    cpu_read(BASE + 4*9, r);
    check("R2 write goes to bank not in use", r, 32'(pat_b(9)));
  endtask

  initial begin
    t_reset();
    t_first_swap();
    t_refill_and_pending();
    t_no_pending_vblank();
    t_idle_lookup();
    t_same_cycle();
    t_misaligned_unmapped();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule